// File: doc/BRIEF.md
# Linked-List DMA Channel Controller

This block is one DMA channel that works through a chain of descriptors kept in memory. Each descriptor is four 32-bit words read in order: source address, destination address, a size word and a link word. The size word carries a byte count and, in its top bit, a valid flag used only in ring mode. The link word carries the next descriptor address in its upper bits and four flags in its low nibble. Those flags give the address space of the next descriptor, mark the end of the chain, request an interrupt and set the transfer direction. Data moves one word per beat: a read request on one port, then a write request on the other. Each of the three request ports (descriptor, data read, data write) uses a level request that completes on an acknowledge. The acknowledge may come in the same cycle as the request.

Software uses three word registers. Index 0 is control: bit 0 enables the channel, bit 1 is a write-only start strobe, and bit 2 turns on ring mode. Index 1 is status: bit 0 is done and bit 1 is interrupt, both sticky and cleared by writing 1; bit 2 is busy and is read-only. Index 2 is the descriptor pointer: bit 0 selects the space (1 host, 0 local) and bits 31:4 give the 16-byte-aligned address. Index 3 reads zero. The interrupt output follows the interrupt status bit.

The sequencer has six states. IDLE goes to FETCH on a start strobe while enable is set. FETCH reads four words and then goes to CHECK. CHECK goes back to IDLE if ring mode sees an invalid descriptor, goes to NEXT if the count is zero, and otherwise goes to READ. READ goes to WRITE on a read acknowledge, but only while enabled. WRITE goes to NEXT when the count is used up, and otherwise back to READ. NEXT copies the link word into the pointer register, then goes to IDLE on end of chain or to FETCH otherwise.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and no request is raised.
- R2: A start strobe begins a run only if enable was already 1 before that write; writing enable and start together in one write leaves the channel idle.
- R3: A descriptor is fetched as four words at byte offsets 0, 4, 8 and 12 from the pointer address (bits 31:4), in the space given by pointer bit 0 (1 host, 0 local).
- R4: Each data beat reads one word at the source and then writes it at the destination. Both addresses then advance by 4 and the count falls by 4, saturating at zero. A count of zero moves no data. Only size bits 22:0 form the count.
- R5: Link bit 3 set reads from local space and writes to host space. Link bit 3 clear reads from host space and writes to local space.
- R6: When a descriptor finishes, the pointer register takes that descriptor's link word. If link bit 1 is set, the channel stops and sets done (status bit 0). Otherwise it fetches the next descriptor.
- R7: A finished descriptor with link bit 2 set sets the sticky interrupt status (status bit 1), and the interrupt output follows that bit.
- R8: Writing 1 to a status bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: While enable is 0, no new data read is launched and progress is held. Setting enable again resumes from the same point with no data lost.
- R10: In ring mode (control bit 2), a descriptor whose size bit 31 is 0 sends the channel back to idle with the pointer unchanged, and a later start fetches it again. With ring mode off, bit 31 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Descriptor word byte address |
| dsc_space | output | 1 | Descriptor space, 1 host / 0 local |
| dsc_ack | input | 1 | Descriptor read acknowledge |
| dsc_rdata | input | 32 | Descriptor word data |
| rd_req | output | 1 | Data read request |
| rd_addr | output | 32 | Data read byte address |
| rd_space | output | 1 | Data read space |
| rd_ack | input | 1 | Data read acknowledge |
| rd_data | input | DW | Data read word |
| wr_req | output | 1 | Data write request |
| wr_addr | output | 32 | Data write byte address |
| wr_space | output | 1 | Data write space |
| wr_data | output | DW | Data write word |
| wr_ack | input | 1 | Data write acknowledge |
| irq | output | 1 | Interrupt, mirrors interrupt status |

## Verification
Two things can land on the status bits in the same cycle: the NEXT state setting done and interrupt, and a software write of 1s that clears them. The bench makes them collide by watching for the last write request of a one-beat descriptor. It then issues the clearing write on the next cycle, which is NEXT. It expects both bits to read back as 1, because the set wins, and expects a second clearing write to take them to zero. The same cycle-exact watching of requests is used to drop enable in the middle of a transfer, to confirm that no read is issued during the pause.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_NEXT
    } dma_state_t;

    localparam logic [1:0] RIDX_CTRL = 2'd0;
    localparam logic [1:0] RIDX_STAT = 2'd1;
    localparam logic [1:0] RIDX_PTR  = 2'd2;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_GO   = 1;
    localparam int CTRL_RING = 2;

    localparam int STAT_DONE = 0;
    localparam int STAT_IRQ  = 1;
    localparam int STAT_BUSY = 2;

    localparam int LNK_SPACE = 0;
    localparam int LNK_LAST  = 1;
    localparam int LNK_IRQ   = 2;
    localparam int LNK_DIR   = 3;
    localparam int SZ_VALID  = 31;
    localparam int ALIGN_B   = 4;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_i,
    input  logic        done_set_i,
    input  logic        irq_set_i,
    input  logic        ptr_load_i,
    input  logic [31:0] ptr_next_i,
    output logic        enable_o,
    output logic        ring_o,
    output logic        go_o,
    output logic [31-ALIGN_B:0] ptr_base_o,
    output logic        ptr_space_o,
    output logic        irq_o
);
    logic        en_q, ring_q, done_q, irq_q;
    logic [31:0] ptr_q;
    logic        wr_ctrl, wr_stat, wr_ptr;

    assign wr_ctrl = reg_wr && (reg_addr == RIDX_CTRL);
    assign wr_stat = reg_wr && (reg_addr == RIDX_STAT);
    assign wr_ptr  = reg_wr && (reg_addr == RIDX_PTR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ring_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[CTRL_EN];
                ring_q <= reg_wdata[CTRL_RING];
            end
            done_q <= done_set_i | (done_q & ~(wr_stat & reg_wdata[STAT_DONE]));
            irq_q  <= irq_set_i  | (irq_q  & ~(wr_stat & reg_wdata[STAT_IRQ]));
            if (ptr_load_i)
                ptr_q <= ptr_next_i;
            else if (wr_ptr && !busy_i)
                ptr_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RIDX_CTRL: reg_rdata = {29'd0, ring_q, 1'b0, en_q};
            RIDX_STAT: reg_rdata = {29'd0, busy_i, irq_q, done_q};
            RIDX_PTR:  reg_rdata = ptr_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign enable_o    = en_q;
    assign ring_o      = ring_q;
    assign go_o        = wr_ctrl && reg_wdata[CTRL_GO];
    assign ptr_base_o  = ptr_q[31:ALIGN_B];
    assign ptr_space_o = ptr_q[LNK_SPACE];
    assign irq_o       = irq_q;

    // R8
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_i |=> irq_q);
    // R6
    done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set_i |=> done_q);
    // R3
    ptr_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !ptr_load_i) |=> $stable(ptr_q));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          ring_i,
    input  logic          go_i,
    input  logic [31-ALIGN_B:0] ptr_base_i,
    input  logic          ptr_space_i,
    output logic          dsc_req_o,
    output logic [31:0]   dsc_addr_o,
    output logic          dsc_space_o,
    input  logic          dsc_ack_i,
    input  logic [31:0]   dsc_rdata_i,
    output logic          rd_req_o,
    output logic [31:0]   rd_addr_o,
    output logic          rd_space_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [31:0]   wr_addr_o,
    output logic          wr_space_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    output logic          busy_o,
    output logic          done_set_o,
    output logic          irq_set_o,
    output logic          ptr_load_o,
    output logic [31:0]   ptr_next_o
);
    localparam int WORDS = 4;
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] BEAT_C = CNT_W'(DW / 8);

    dma_state_t       state_q, state_d;
    logic [IDX_W-1:0] widx_q;
    logic [31:0]      src_q, dst_q, link_q;
    logic [CNT_W-1:0] cnt_q, cnt_after;
    logic             valid_q;
    logic [DW-1:0]    buf_q;

    assign cnt_after = (cnt_q <= BEAT_C) ? '0 : cnt_q - BEAT_C;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go_i && enable_i) state_d = S_FETCH;
            S_FETCH: if (dsc_ack_i && widx_q == IDX_W'(WORDS - 1)) state_d = S_CHECK;
            S_CHECK: begin
                if (ring_i && !valid_q)  state_d = S_IDLE;
                else if (cnt_q == '0)    state_d = S_NEXT;
                else                     state_d = S_READ;
            end
            S_READ:  if (enable_i && rd_ack_i) state_d = S_WRITE;
            S_WRITE: if (wr_ack_i) state_d = (cnt_after == '0) ? S_NEXT : S_READ;
            S_NEXT:  state_d = link_q[LNK_LAST] ? S_IDLE : S_FETCH;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        dsc_req_o  = (state_q == S_FETCH);
        rd_req_o   = (state_q == S_READ) && enable_i;
        wr_req_o   = (state_q == S_WRITE);
        ptr_load_o = (state_q == S_NEXT);
        done_set_o = ptr_load_o && link_q[LNK_LAST];
        irq_set_o  = ptr_load_o && link_q[LNK_IRQ];
        busy_o     = (state_q != S_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            link_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            buf_q   <= '0;
        end else begin
            if (state_q == S_IDLE || state_q == S_NEXT)
                widx_q <= '0;
            if (dsc_req_o && dsc_ack_i) begin
                widx_q <= widx_q + 1'b1;
                unique case (widx_q)
                    2'd0: src_q <= dsc_rdata_i;
                    2'd1: dst_q <= dsc_rdata_i;
                    2'd2: begin
                        cnt_q   <= dsc_rdata_i[CNT_W-1:0];
                        valid_q <= dsc_rdata_i[SZ_VALID];
                    end
                    default: link_q <= dsc_rdata_i;
                endcase
            end
            if (rd_req_o && rd_ack_i)
                buf_q <= rd_data_i;
            if (wr_req_o && wr_ack_i) begin
                src_q <= src_q + 32'(DW / 8);
                dst_q <= dst_q + 32'(DW / 8);
                cnt_q <= cnt_after;
            end
        end
    end

    assign dsc_addr_o  = {ptr_base_i, widx_q, 2'b00};
    assign dsc_space_o = ptr_space_i;
    assign rd_addr_o   = src_q;
    assign rd_space_o  = ~link_q[LNK_DIR];
    assign wr_addr_o   = dst_q;
    assign wr_space_o  = link_q[LNK_DIR];
    assign wr_data_o   = buf_q;
    assign ptr_next_o  = link_q;

    // R2
    no_start_unless_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && go_i && !enable_i) |=> !busy_o);
    // R9
    pause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ && !enable_i) |=> (state_q == S_READ && $stable(cnt_q) && $stable(src_q)));
    // R10
    ring_invalid_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && ring_i && !valid_q) |=> (state_q == S_IDLE));
    // R4
    count_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i) |=> (cnt_q < $past(cnt_q)));
    // R6
    last_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set_o |=> !busy_o);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          dsc_req,
    output logic [31:0]   dsc_addr,
    output logic          dsc_space,
    input  logic          dsc_ack,
    input  logic [31:0]   dsc_rdata,
    output logic          rd_req,
    output logic [31:0]   rd_addr,
    output logic          rd_space,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic [31:0]   wr_addr,
    output logic          wr_space,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    output logic          irq
);
    logic        enable, ring, go, busy, done_set, irq_set, ptr_load, ptr_space;
    logic [31:0] ptr_next;
    logic [31-ALIGN_B:0] ptr_base;

    dma_chain_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .done_set_i (done_set),
        .irq_set_i  (irq_set),
        .ptr_load_i (ptr_load),
        .ptr_next_i (ptr_next),
        .enable_o   (enable),
        .ring_o     (ring),
        .go_o       (go),
        .ptr_base_o (ptr_base),
        .ptr_space_o(ptr_space),
        .irq_o      (irq)
    );

    dma_chain_engine #(.DW(DW), .CNT_W(CNT_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .ring_i     (ring),
        .go_i       (go),
        .ptr_base_i (ptr_base),
        .ptr_space_i(ptr_space),
        .dsc_req_o  (dsc_req),
        .dsc_addr_o (dsc_addr),
        .dsc_space_o(dsc_space),
        .dsc_ack_i  (dsc_ack),
        .dsc_rdata_i(dsc_rdata),
        .rd_req_o   (rd_req),
        .rd_addr_o  (rd_addr),
        .rd_space_o (rd_space),
        .rd_ack_i   (rd_ack),
        .rd_data_i  (rd_data),
        .wr_req_o   (wr_req),
        .wr_addr_o  (wr_addr),
        .wr_space_o (wr_space),
        .wr_data_o  (wr_data),
        .wr_ack_i   (wr_ack),
        .busy_o     (busy),
        .done_set_o (done_set),
        .irq_set_o  (irq_set),
        .ptr_load_o (ptr_load),
        .ptr_next_o (ptr_next)
    );
endmodule

// File: tb/dma_chain_ctrl_tb.sv
module dma_chain_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dsc_req, dsc_space, rd_req, rd_space, wr_req, wr_space, irq;
    logic [31:0] dsc_addr, rd_addr, wr_addr, wr_data;
    logic        dsc_ack, rd_ack, wr_ack;
    logic [31:0] dsc_rdata, rd_data;

    logic [31:0] host_mem [64];
    logic [31:0] local_mem[64];
    logic        tb_we = 1'b0;
    logic        tb_sp = 1'b0;
    int          tb_idx = 0;
    logic [31:0] tb_dat = '0;
    int          rd_beats = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    assign dsc_ack   = dsc_req;
    assign dsc_rdata = dsc_space ? host_mem[dsc_addr[7:2]] : local_mem[dsc_addr[7:2]];
    assign rd_ack    = rd_req;
    assign rd_data   = rd_space ? host_mem[rd_addr[7:2]] : local_mem[rd_addr[7:2]];
    assign wr_ack    = wr_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                host_mem[i]  <= '0;
                local_mem[i] <= '0;
            end
        end else begin
            if (wr_req) begin
                if (wr_space) host_mem[wr_addr[7:2]]  <= wr_data;
                else          local_mem[wr_addr[7:2]] <= wr_data;
            end
            if (tb_we) begin
                if (tb_sp) host_mem[tb_idx]  <= tb_dat;
                else       local_mem[tb_idx] <= tb_dat;
            end
        end
        if (rd_req) rd_beats <= rd_beats + 1;
    end

    dma_chain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_space(dsc_space),
        .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_space(rd_space),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_space(wr_space),
        .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] cnt;
        logic       dir;
        logic       irqen;
        logic [3:0] beats;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{cnt: 8'd16, dir: 1'b0, irqen: 1'b1, beats: 4'd4},
        '{cnt: 8'd4,  dir: 1'b1, irqen: 1'b0, beats: 4'd1},
        '{cnt: 8'd10, dir: 1'b0, irqen: 1'b0, beats: 4'd3},
        '{cnt: 8'd0,  dir: 1'b1, irqen: 1'b1, beats: 4'd0},
        '{cnt: 8'd8,  dir: 1'b1, irqen: 1'b1, beats: 4'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic mem_wr(input logic sp, input int idx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_sp = sp; tb_idx = idx; tb_dat = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            reg_read(2'd1, s);
            if (!s[2]) break;
        end
    endtask

    task automatic wait_wr();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (wr_req) break;
        end
    endtask

    function automatic logic [31:0] pat(input int v, input int k);
        return 32'hA500_0000 | (32'(v) << 8) | 32'(k);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int b0, b1;
        logic sp_src;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, r); chk(r == 32'd0, "R1 ctrl", r, 32'd0);
        reg_read(2'd1, r); chk(r == 32'd0, "R1 status", r, 32'd0);
        reg_read(2'd2, r); chk(r == 32'd0, "R1 pointer", r, 32'd0);
        chk({dsc_req, rd_req, wr_req, irq} == 4'd0, "R1 requests", {28'd0, dsc_req, rd_req, wr_req, irq}, 32'd0);

        // R2 enable and start in one write: stays idle
        mem_wr(1'b1, 0, 32'h40); mem_wr(1'b1, 1, 32'h80);
        mem_wr(1'b1, 2, 32'd4);  mem_wr(1'b1, 3, 32'h2);
        reg_write(2'd2, 32'h1);
        b0 = rd_beats;
        reg_write(2'd0, 32'h3);
        repeat (10) @(negedge clk);
        reg_read(2'd1, r); chk(r == 32'd0, "R2 no start without prior enable", r, 32'd0);
        chk(rd_beats == b0, "R2 no beats", 32'(rd_beats - b0), 32'd0);

        // Table of single-descriptor runs: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            sp_src = ~VECS[v].dir;
            for (int k = 0; k < 4; k++) begin
                mem_wr(sp_src, 16 + k, pat(v, k));
                mem_wr(~sp_src, 32 + k, 32'd0);
            end
            mem_wr(1'b1, 0, 32'h40);
            mem_wr(1'b1, 1, 32'h80);
            mem_wr(1'b1, 2, {24'd0, VECS[v].cnt});
            mem_wr(1'b1, 3, {28'd0, VECS[v].dir, VECS[v].irqen, 2'b10});
            reg_write(2'd2, 32'h1);
            reg_write(2'd0, 32'h1);
            b0 = rd_beats;
            reg_write(2'd0, 32'h3);
            wait_idle();
            chk(rd_beats - b0 == int'(VECS[v].beats), "R4 beat count", 32'(rd_beats - b0), 32'(VECS[v].beats));
            for (int k = 0; k < 4; k++) begin
                r = sp_src ? local_mem[32 + k] : host_mem[32 + k];
                if (k < int'(VECS[v].beats))
                    chk(r == pat(v, k), "R5 moved word", r, pat(v, k));
                else
                    chk(r == 32'd0, "R4 untouched word", r, 32'd0);
            end
            reg_read(2'd1, r);
            chk(r == {30'd0, VECS[v].irqen, 1'b1}, "R6 R7 status", r, {30'd0, VECS[v].irqen, 1'b1});
            chk(irq == VECS[v].irqen, "R7 irq pin", {31'd0, irq}, {31'd0, VECS[v].irqen});
            reg_write(2'd1, 32'h3);
        end

        // R6 R3 two-descriptor chain, second descriptor in local space
        mem_wr(1'b1, 16, 32'h1111_0001); mem_wr(1'b1, 17, 32'h1111_0002);
        mem_wr(1'b0, 24, 32'h2222_0003);
        mem_wr(1'b0, 32, 32'd0); mem_wr(1'b0, 33, 32'd0); mem_wr(1'b1, 40, 32'd0);
        mem_wr(1'b1, 0, 32'h40); mem_wr(1'b1, 1, 32'h80);
        mem_wr(1'b1, 2, 32'd8);  mem_wr(1'b1, 3, 32'h20);
        mem_wr(1'b0, 8, 32'h60); mem_wr(1'b0, 9, 32'hA0);
        mem_wr(1'b0, 10, 32'd4); mem_wr(1'b0, 11, 32'hE);
        reg_write(2'd2, 32'h1);
        b0 = rd_beats;
        reg_write(2'd0, 32'h3);
        wait_idle();
        chk(local_mem[33] == 32'h1111_0002, "R6 first link data", local_mem[33], 32'h1111_0002);
        chk(host_mem[40] == 32'h2222_0003, "R6 second link data", host_mem[40], 32'h2222_0003);
        chk(rd_beats - b0 == 3, "R6 chain beats", 32'(rd_beats - b0), 32'd3);
        reg_read(2'd2, r); chk(r == 32'hE, "R6 pointer takes link", r, 32'hE);
        reg_read(2'd1, r); chk(r == 32'h3, "R6 done after chain", r, 32'h3);
        reg_write(2'd1, 32'h3);

        // R9 pause and resume
        for (int k = 0; k < 4; k++) begin
            mem_wr(1'b1, 16 + k, pat(9, k));
            mem_wr(1'b0, 32 + k, 32'd0);
        end
        mem_wr(1'b1, 0, 32'h40); mem_wr(1'b1, 1, 32'h80);
        mem_wr(1'b1, 2, 32'd16); mem_wr(1'b1, 3, 32'h2);
        reg_write(2'd2, 32'h1);
        reg_write(2'd0, 32'h3);
        wait_wr();
        reg_write(2'd0, 32'h0);
        b0 = rd_beats;
        repeat (20) @(negedge clk);
        b1 = rd_beats;
        chk(b1 == b0, "R9 no reads while paused", 32'(b1 - b0), 32'd0);
        reg_read(2'd1, r); chk(r[2] == 1'b1, "R9 still busy in pause", r, 32'h4);
        reg_write(2'd0, 32'h1);
        wait_idle();
        for (int k = 0; k < 4; k++)
            chk(local_mem[32 + k] == pat(9, k), "R9 resumed data", local_mem[32 + k], pat(9, k));
        reg_write(2'd1, 32'h3);

        // R10 ring mode, invalid descriptor parks the channel
        mem_wr(1'b1, 16, 32'h5A5A_0001); mem_wr(1'b0, 32, 32'd0);
        mem_wr(1'b1, 2, 32'd4); mem_wr(1'b1, 3, 32'h2);
        reg_write(2'd2, 32'h1);
        reg_write(2'd0, 32'h5);
        b0 = rd_beats;
        reg_write(2'd0, 32'h7);
        repeat (15) @(negedge clk);
        reg_read(2'd1, r); chk(r == 32'd0, "R10 invalid stops idle", r, 32'd0);
        chk(rd_beats == b0, "R10 no data on invalid", 32'(rd_beats - b0), 32'd0);
        reg_read(2'd2, r); chk(r == 32'h1, "R10 pointer unchanged", r, 32'h1);
        mem_wr(1'b1, 2, 32'h8000_0004);
        reg_write(2'd0, 32'h7);
        wait_idle();
        chk(local_mem[32] == 32'h5A5A_0001, "R10 refetch valid runs", local_mem[32], 32'h5A5A_0001);
        reg_write(2'd1, 32'h3);
        // R10 ring off ignores bit 31
        mem_wr(1'b1, 16, 32'h5A5A_0002); mem_wr(1'b0, 32, 32'd0);
        mem_wr(1'b1, 2, 32'd4);
        reg_write(2'd2, 32'h1);
        reg_write(2'd0, 32'h1);
        reg_write(2'd0, 32'h3);
        wait_idle();
        chk(local_mem[32] == 32'h5A5A_0002, "R10 ring off ignores valid", local_mem[32], 32'h5A5A_0002);
        reg_write(2'd1, 32'h3);

        // R8 set and write-1-clear in the same cycle
        mem_wr(1'b1, 16, 32'h7777_0001);
        mem_wr(1'b1, 2, 32'd4); mem_wr(1'b1, 3, 32'h6);
        reg_write(2'd2, 32'h1);
        reg_write(2'd0, 32'h3);
        wait_wr();
        reg_write(2'd1, 32'h3);
        reg_read(2'd1, r); chk(r == 32'h3, "R8 set wins over clear", r, 32'h3);
        reg_write(2'd1, 32'h3);
        reg_read(2'd1, r); chk(r == 32'h0, "R8 write one clears", r, 32'h0);
        chk(irq == 1'b0, "R7 irq pin follows clear", {31'd0, irq}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule